// File: doc/BRIEF.md
# Locked Bus Cycle Output Controller

This block is the output stage of a bus master on a 32-bit processor bus. For each bus cycle it drives the transfer direction, the transfer size, a "locked" flag and a "lock end" flag. Each of these outputs has its own drive value and its own output enable, so the pad ring can float them whenever another master owns the bus. Transfer requests come from the core one per clock-enabled cycle. A request carries a direction, a size code and the lock flags.

Bus ownership follows two arbiter inputs. The first is a grant. The second is a "release and retain" request that forces the master to yield even in the middle of a locked sequence. When the bus is given up, the lock and lock-end outputs do not float at once. They follow a short release sequence tied to an address-idle marker from the address path. If the pin was asserted, it is driven negated first and floats one cycle after the idle cycle. If the pin was already negated, it floats during the idle cycle itself.

Every register changes only on rising clock edges where the clock enable is high. Reset is synchronous and active low.

Top module: `lkbus_out_ctl`

## Requirements
- R1: While owning the bus, `dir_o` is 1 for a read request and 0 for a write request, one clock-enabled edge after the request is presented with `req_valid_i` high.
- R2: While owning the bus, `size_o` carries the request's size code one clock-enabled edge after acceptance: 00 means 4 bytes, 01 means 1 byte, 10 means 2 bytes and 11 means a 16-byte line.
- R3: After reset and whenever the block does not own the bus (`owner_o` = 0), `dir_oe_o` and `size_oe_o` are 0. After reset, `lock_oe_o` and `locke_oe_o` are also 0.
- R4: Ownership is taken on a clock-enabled edge where `bg_i` is 1 and no release sequence is pending. While either lock pin is still in its release sequence, a grant is not taken.
- R5: With `bg_i` low, a high `bgr_i` gives up the bus at the next clock-enabled edge even while `lock_o` is asserted. With `bg_i` low and `bgr_i` low, the bus is kept only while `lock_o` is asserted.
- R6: `lock_o` (1 = asserted) is asserted on every cycle of a locked sequence, including cycles with no new request. It is 0 after a new ownership starts until a locked request arrives.
- R7: `locke_o` (1 = asserted) is asserted only on the last request of a locked sequence. It is held low while `retry_i` is high and that request is the final write of a read-modify-write.
- R8: If the bus is given up with `lock_o` asserted, `lock_o` is driven 0 with `lock_oe_o` = 1 from the next cycle. The pin stays driven through the cycle in which `addr_idle_i` is high and floats from the following clock-enabled edge.
- R9: If the bus is given up with a lock pin already negated, that pin is driven 0 until the cycle in which `addr_idle_i` is high. It floats in that same cycle.
- R10: `locke_o` follows the same release sequences as `lock_o`: R8 if it was asserted at give-up, R9 if not.
- R11: With `clk_en` low, ownership and all output values hold, and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; state changes only when high |
| bg_i | input | 1 | Bus grant from the arbiter |
| bgr_i | input | 1 | Arbiter demand to release the bus even when locked |
| addr_idle_i | input | 1 | High in the cycle the address bus goes idle |
| req_valid_i | input | 1 | Core presents a transfer request |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_size_i | input | 2 | Size code (see R2) |
| req_lock_i | input | 1 | Request belongs to a locked sequence |
| req_lock_end_i | input | 1 | Request is the last of its locked sequence |
| req_rmw_wr_i | input | 1 | Request is the final write of a read-modify-write |
| retry_i | input | 1 | Current cycle is being terminated with retry |
| owner_o | output | 1 | Block owns the bus |
| dir_o | output | 1 | Direction drive value |
| dir_oe_o | output | 1 | Direction output enable |
| size_o | output | 2 | Size drive value |
| size_oe_o | output | 1 | Size output enable |
| lock_o | output | 1 | Lock drive value |
| lock_oe_o | output | 1 | Lock output enable |
| locke_o | output | 1 | Lock-end drive value |
| locke_oe_o | output | 1 | Lock-end output enable |

## Verification
The bench builds the block with its default parameters: a 2-bit size field and two lock-style pins, each with its own release sequencer. At these values the bench can drive all four size codes. It can also steer each release sequencer down both paths, starting from an asserted pin and from a negated pin. The bench also covers a grant that arrives while the release is still pending, and a retried read-modify-write final write that must keep lock-end low.

// File: rtl/lkbus_pkg.sv
// Package: shared widths and encodings for the locked bus output controller.
// Assumes: the size field is two bits wide and its code values are fixed by the bus.
package lkbus_pkg;
    localparam int SIZE_W = 2;

    // Transfer size codes as driven on the bus.
    typedef enum logic [SIZE_W-1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    // Release sequencer state for a lock-style pin.
    typedef enum logic [1:0] {
        REL_OFF   = 2'b00,
        REL_DRIVE = 2'b01,
        REL_NEG   = 2'b10,
        REL_QUIET = 2'b11
    } rel_state_e;
endpackage

// File: rtl/lkbus_owner.sv
// Module: bus ownership tracker.
// Takes the bus on a grant once every release sequence is complete. Gives the bus
// up when the grant drops, unless a locked sequence is active and the arbiter
// has not demanded release.
// Assumes: gain_o and give_up_o are acted on by consumers only when clk_en is high.
module lkbus_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic bg_i,
    input  logic bgr_i,
    input  logic lock_active_i,
    input  logic release_done_i,
    output logic owner_o,
    output logic gain_o,
    output logic give_up_o
);
    logic owner_q;

    // Decide gain and give-up from the arbiter inputs and the lock state.
    always_comb begin
        gain_o    = ~owner_q & bg_i & release_done_i;
        give_up_o = owner_q & ~bg_i & (bgr_i | ~lock_active_i);
    end

    // Ownership register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
        end else if (clk_en) begin
            if (gain_o) begin
                owner_q <= 1'b1;
            end else if (give_up_o) begin
                owner_q <= 1'b0;
            end
        end
    end

    assign owner_o = owner_q;
endmodule

// File: rtl/lkbus_cycle_reg.sv
// Module: per-cycle attribute register.
// Captures direction, size and lock flags of each accepted request while the bus
// is owned. Lock flags are cleared when the bus is given up, so a new ownership
// starts unlocked.
// Assumes: the core presents at most one request per clock-enabled cycle.
module lkbus_cycle_reg #(
    parameter int SIZE_W = lkbus_pkg::SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              owner_i,
    input  logic              give_up_i,
    input  logic              req_valid_i,
    input  logic              req_read_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic              req_lock_i,
    input  logic              req_lock_end_i,
    input  logic              req_rmw_wr_i,
    output logic              dir_q_o,
    output logic [SIZE_W-1:0] size_q_o,
    output logic              lock_q_o,
    output logic              locke_q_o,
    output logic              rmw_q_o
);
    // Load request attributes, clear lock flags on give-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q_o   <= 1'b1;
            size_q_o  <= '0;
            lock_q_o  <= 1'b0;
            locke_q_o <= 1'b0;
            rmw_q_o   <= 1'b0;
        end else if (clk_en) begin
            if (give_up_i) begin
                lock_q_o  <= 1'b0;
                locke_q_o <= 1'b0;
                rmw_q_o   <= 1'b0;
            end else if (owner_i && req_valid_i) begin
                dir_q_o   <= req_read_i;
                size_q_o  <= req_size_i;
                lock_q_o  <= req_lock_i;
                locke_q_o <= req_lock_i & req_lock_end_i;
                rmw_q_o   <= req_rmw_wr_i;
            end
        end
    end
endmodule

// File: rtl/lkbus_release.sv
// Module: release sequencer for one lock-style pin.
// While owned, the pin carries its live value. On give-up, an asserted pin is
// driven negated until the cycle after the address-idle marker. A negated pin
// floats in the address-idle cycle itself.
// Assumes: addr_idle_i is a single clock-enabled cycle pulse after each give-up.
module lkbus_release (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic gain_i,
    input  logic give_up_i,
    input  logic drv_i,
    input  logic addr_idle_i,
    output logic pin_o,
    output logic pin_oe_o,
    output logic idle_o
);
    import lkbus_pkg::*;

    rel_state_e st_q;

    // State sequencing across gain, give-up and address idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= REL_OFF;
        end else if (clk_en) begin
            unique case (st_q)
                REL_OFF:   if (gain_i) st_q <= REL_DRIVE;
                REL_DRIVE: if (give_up_i) st_q <= drv_i ? REL_NEG : REL_QUIET;
                REL_NEG:   if (addr_idle_i) st_q <= REL_OFF;
                REL_QUIET: if (addr_idle_i) st_q <= REL_OFF;
                default:   st_q <= REL_OFF;
            endcase
        end
    end

    // Drive value and enable from the state and the idle marker.
    always_comb begin
        pin_o    = (st_q == REL_DRIVE) & drv_i;
        pin_oe_o = (st_q == REL_DRIVE) | (st_q == REL_NEG) |
                   ((st_q == REL_QUIET) & ~addr_idle_i);
        idle_o   = (st_q == REL_OFF);
    end
endmodule

// File: rtl/lkbus_out_ctl.sv
// Module: locked bus cycle output controller (top).
// Drives direction, size, lock and lock-end with separate enables. Tracks bus
// ownership and runs one release sequencer per lock-style pin.
// Assumes: the external pad ring turns each value/enable pair into a three-state pin.
module lkbus_out_ctl #(
    parameter int SIZE_W = lkbus_pkg::SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              bg_i,
    input  logic              bgr_i,
    input  logic              addr_idle_i,
    input  logic              req_valid_i,
    input  logic              req_read_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic              req_lock_i,
    input  logic              req_lock_end_i,
    input  logic              req_rmw_wr_i,
    input  logic              retry_i,
    output logic              owner_o,
    output logic              dir_o,
    output logic              dir_oe_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              size_oe_o,
    output logic              lock_o,
    output logic              lock_oe_o,
    output logic              locke_o,
    output logic              locke_oe_o
);
    localparam int NPIN     = 2;
    localparam int PIN_LOCK = 0;
    localparam int PIN_LEND = 1;

    logic              owner, gain, give_up;
    logic              dir_q, lock_q, locke_q, rmw_q;
    logic [SIZE_W-1:0] size_q;
    logic [NPIN-1:0]   pin_val, pin_drv, pin_oe, pin_idle;

    lkbus_owner u_owner (
        .clk            (clk),
        .rst_n          (rst_n),
        .clk_en         (clk_en),
        .bg_i           (bg_i),
        .bgr_i          (bgr_i),
        .lock_active_i  (pin_val[PIN_LOCK]),
        .release_done_i (&pin_idle),
        .owner_o        (owner),
        .gain_o         (gain),
        .give_up_o      (give_up)
    );

    lkbus_cycle_reg #(.SIZE_W(SIZE_W)) u_cyc (
        .clk            (clk),
        .rst_n          (rst_n),
        .clk_en         (clk_en),
        .owner_i        (owner),
        .give_up_i      (give_up),
        .req_valid_i    (req_valid_i),
        .req_read_i     (req_read_i),
        .req_size_i     (req_size_i),
        .req_lock_i     (req_lock_i),
        .req_lock_end_i (req_lock_end_i),
        .req_rmw_wr_i   (req_rmw_wr_i),
        .dir_q_o        (dir_q),
        .size_q_o       (size_q),
        .lock_q_o       (lock_q),
        .locke_q_o      (locke_q),
        .rmw_q_o        (rmw_q)
    );

    // Live lock values; lock-end is suppressed on a retried final RMW write.
    always_comb begin
        pin_val[PIN_LOCK] = lock_q & owner;
        pin_val[PIN_LEND] = locke_q & ~(rmw_q & retry_i) & owner;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_rel
        lkbus_release u_rel (
            .clk         (clk),
            .rst_n       (rst_n),
            .clk_en      (clk_en),
            .gain_i      (gain),
            .give_up_i   (give_up),
            .drv_i       (pin_val[g]),
            .addr_idle_i (addr_idle_i),
            .pin_o       (pin_drv[g]),
            .pin_oe_o    (pin_oe[g]),
            .idle_o      (pin_idle[g])
        );
    end

    // Output mapping.
    always_comb begin
        owner_o    = owner;
        dir_o      = dir_q;
        dir_oe_o   = owner;
        size_o     = size_q;
        size_oe_o  = owner;
        lock_o     = pin_drv[PIN_LOCK];
        lock_oe_o  = pin_oe[PIN_LOCK];
        locke_o    = pin_drv[PIN_LEND];
        locke_oe_o = pin_oe[PIN_LEND];
    end
endmodule

// File: rtl/lkbus_out_ctl_chk.sv
// Module: property checker for the locked bus output controller, bound to the top.
module lkbus_out_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic       bg_i,
    input logic       bgr_i,
    input logic       owner_o,
    input logic       dir_o,
    input logic       dir_oe_o,
    input logic [1:0] size_o,
    input logic       size_oe_o,
    input logic       lock_o,
    input logic       lock_oe_o,
    input logic       locke_o
);
    p_float_unowned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_o |-> (!dir_oe_o && !size_oe_o));

    p_no_gain_without_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !owner_o && !bg_i) |=> !owner_o);

    p_bgr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && owner_o && !bg_i && bgr_i) |=> !owner_o);

    p_keep_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && owner_o && !bg_i && !bgr_i && lock_o) |=> owner_o);

    p_locke_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locke_o |-> lock_o);

    p_neg_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && owner_o && !bg_i && bgr_i && lock_o) |=> (lock_oe_o && !lock_o));

    p_no_lock_unowned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_o |-> !lock_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(owner_o) && $stable(dir_o) && $stable(size_o)));
endmodule

bind lkbus_out_ctl lkbus_out_ctl_chk u_chk (.*);

// File: tb/sim_lkbus_out_ctl.sv
module sim_lkbus_out_ctl;
    logic       clk = 1'b0;
    logic       rst_n, clk_en, bg_i, bgr_i, addr_idle_i;
    logic       req_valid_i, req_read_i, req_lock_i, req_lock_end_i, req_rmw_wr_i, retry_i;
    logic [1:0] req_size_i;
    logic       owner_o, dir_o, dir_oe_o, size_oe_o, lock_o, lock_oe_o, locke_o, locke_oe_o;
    logic [1:0] size_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    lkbus_out_ctl u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic rd, input logic [1:0] sz, input logic lk,
                         input logic lend, input logic rmw);
        req_valid_i = 1'b1; req_read_i = rd; req_size_i = sz;
        req_lock_i = lk; req_lock_end_i = lend; req_rmw_wr_i = rmw;
        tick();
        req_valid_i = 1'b0; req_lock_i = 1'b0; req_lock_end_i = 1'b0; req_rmw_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R3 owner after reset", owner_o, 0);
        chk("R3 dir_oe after reset", dir_oe_o, 0);
        chk("R3 size_oe after reset", size_oe_o, 0);
        chk("R3 lock_oe after reset", lock_oe_o, 0);
        chk("R3 locke_oe after reset", locke_oe_o, 0);
    endtask

    task automatic t_grant();
        bg_i = 1'b1;
        tick();
        chk("R4 owner on grant", owner_o, 1);
        chk("R3 dir_oe when owned", dir_oe_o, 1);
        chk("R3 size_oe when owned", size_oe_o, 1);
        chk("R6 lock idle after grant", lock_o, 0);
    endtask

    task automatic t_encode();
        issue(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        chk("R1 read dir", dir_o, 1);
        chk("R2 byte code", size_o, 1);
        issue(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        chk("R1 write dir", dir_o, 0);
        chk("R2 line code", size_o, 3);
        issue(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        chk("R2 word code", size_o, 2);
        issue(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R2 long code", size_o, 0);
    endtask

    task automatic t_clken();
        clk_en = 1'b0;
        bg_i = 1'b0; bgr_i = 1'b1;
        issue(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        chk("R11 dir held", dir_o, 0);
        chk("R11 size held", size_o, 0);
        chk("R11 owner held", owner_o, 1);
        bg_i = 1'b1; bgr_i = 1'b0; clk_en = 1'b1;
    endtask

    task automatic t_lock();
        issue(1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
        chk("R6 lock on locked cycle", lock_o, 1);
        chk("R7 no lock-end mid sequence", locke_o, 0);
        tick();
        chk("R6 lock held between cycles", lock_o, 1);
        retry_i = 1'b1;
        issue(1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R7 lock-end suppressed on retry", locke_o, 0);
        chk("R6 lock on final write", lock_o, 1);
        retry_i = 1'b0;
        #1;
        chk("R7 lock-end on last cycle", locke_o, 1);
    endtask

    task automatic t_keep();
        bg_i = 1'b0; bgr_i = 1'b0;
        tick();
        chk("R5 locked bus kept", owner_o, 1);
    endtask

    task automatic t_release_asserted();
        bgr_i = 1'b1;
        tick();
        chk("R5 give up on bgr", owner_o, 0);
        chk("R3 dir_oe after give-up", dir_oe_o, 0);
        chk("R8 lock driven", lock_oe_o, 1);
        chk("R8 lock negated", lock_o, 0);
        chk("R10 lock-end driven", locke_oe_o, 1);
        chk("R10 lock-end negated", locke_o, 0);
        bg_i = 1'b1;
        tick();
        chk("R4 no gain during release", owner_o, 0);
        chk("R8 lock still driven", lock_oe_o, 1);
        addr_idle_i = 1'b1;
        #1;
        chk("R8 lock driven in idle cycle", lock_oe_o, 1);
        chk("R10 lock-end driven in idle cycle", locke_oe_o, 1);
        tick();
        addr_idle_i = 1'b0; bgr_i = 1'b0;
        chk("R8 lock floats after idle", lock_oe_o, 0);
        chk("R10 lock-end floats after idle", locke_oe_o, 0);
        chk("R4 still not owned", owner_o, 0);
        tick();
        chk("R4 regain after release", owner_o, 1);
        chk("R6 lock cleared on new ownership", lock_o, 0);
    endtask

    task automatic t_release_negated();
        issue(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        bg_i = 1'b0;
        tick();
        chk("R5 unlocked bus released", owner_o, 0);
        chk("R9 lock driven low", lock_oe_o, 1);
        chk("R9 lock value low", lock_o, 0);
        addr_idle_i = 1'b1;
        #1;
        chk("R9 lock floats in idle cycle", lock_oe_o, 0);
        chk("R10 lock-end floats in idle cycle", locke_oe_o, 0);
        tick();
        addr_idle_i = 1'b0;
        chk("R9 lock stays floated", lock_oe_o, 0);
    endtask

    initial begin
        rst_n = 1'b0; clk_en = 1'b1; bg_i = 1'b0; bgr_i = 1'b0; addr_idle_i = 1'b0;
        req_valid_i = 1'b0; req_read_i = 1'b0; req_size_i = 2'b00;
        req_lock_i = 1'b0; req_lock_end_i = 1'b0; req_rmw_wr_i = 1'b0; retry_i = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_grant();
        t_encode();
        t_clken();
        t_lock();
        t_keep();
        t_release_asserted();
        t_release_negated();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule